// File: doc/BRIEF.md
# Ping-Pong Receive Buffer Controller

This block takes received payload in two equal-size network buffers, used in turn. Each arriving packet is reported as a single strobe with its byte count. The block keeps a fill count for the buffer being written and outputs the address where the next payload byte goes. When a packet brings the buffer to a full frame, that buffer is marked ready and writing moves to the other buffer at once, so reception never waits. If a packet carries more bytes than the buffer has room for, the extra bytes start the other buffer at offset zero.

On each periodic display tick, the block looks at the Gray-coded pointer of the display reader, which cycles through three frame slots. If a completed buffer is waiting, the block issues a one-cycle copy command. The command names the completed buffer and its base address as the source. The destination is the display slot one position behind the reader's slot in the ring, so the copy never writes into the frame being shown. A downstream mover carries out the transfer. If a buffer completes while the previous completed buffer has still not been copied, the older frame is dropped and an overrun counter counts the loss.

Top module: `pp_rx_ctrl`

## Requirements
- R1: After a synchronous reset, buffer 0 is active with zero fill, `wr_addr` equals `NET_BASE`, `copy_valid` is low and `overrun_cnt` is zero.
- R2: `wr_addr` always equals `NET_BASE + active*FRAME_BYTES + fill`, where `active` is 0 or 1. A packet strobe of length L that does not complete the buffer raises the fill by L from the next cycle.
- R3: A packet that brings the fill exactly to `FRAME_BYTES` marks the active buffer ready, makes the other buffer active, and resets the fill to zero from the next cycle.
- R4: A packet that takes the fill past `FRAME_BYTES` completes the active buffer, and the excess bytes become the fill of the other buffer, starting at offset zero.
- R5: A tick that finds a ready buffer and a valid pointer raises `copy_valid` for exactly the next cycle. `copy_src_buf` names the completed buffer, which is never the buffer being filled in the tick cycle, and `copy_src_base` gives its base address.
- R6: Pointer codes 2'b00, 2'b01 and 2'b11 mean reader slots 0, 1 and 2. The copy destination is the slot behind the reader: slot 2, slot 0 and slot 1 respectively.
- R7: A tick with no ready buffer issues no command.
- R8: A ready flag clears when its command is issued, so a later tick with no new completion issues nothing.
- R9: When a buffer completes while the other buffer is still ready, the older one is dropped, `overrun_cnt` rises by one, and the next command names the newest buffer.
- R10: A tick with the unused pointer code 2'b10 issues no command and leaves any ready buffer pending.
- R11: If a tick and a completion fall in the same cycle, the command goes to the buffer that was ready before that cycle. The newly completed buffer stays ready, and no overrun is counted.
- R12: A packet strobe with length zero changes nothing. Packet lengths range from 0 to `FRAME_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | One strobe per received packet |
| pkt_len | input | LEN_W | Payload byte count of the strobed packet |
| tick | input | 1 | Periodic display-timer tick |
| rd_gray | input | 2 | Gray-coded reader slot pointer |
| wr_addr | output | ADDR_W | Address of the next payload byte |
| copy_valid | output | 1 | One-cycle copy command |
| copy_src_buf | output | 1 | Index of the network buffer to copy from |
| copy_src_base | output | ADDR_W | Base address of that buffer |
| copy_dst_slot | output | 2 | Display slot to copy into (0 to 2) |
| overrun_cnt | output | OVR_W | Count of completed frames dropped before they were copied |

## Verification
The hardest cases to reach are the ones where a completion and the tick interact: a second completion that arrives before the tick (the overrun), and a completion in the very cycle of a tick. The bench reaches both on purpose. It sends full-frame packets back to back with no tick between them, and it drives a completing packet and a tick in the same cycle. A long random phase then mixes split packets, all four pointer codes and sparse ticks, and a behavioural model checks every cycle.

// File: rtl/pp_rx_pkg.sv
package pp_rx_pkg;

    typedef struct packed {
        logic       valid;
        logic       src;
        logic [1:0] dst;
    } copy_cmd_t;

    // Gray pointer to ring slot; 2'b10 is unused and maps to 3
    function automatic logic [1:0] gray_to_slot(input logic [1:0] g);
        logic [1:0] s;
        s[1] = g[1];
        s[0] = g[1] ^ g[0];
        return s;
    endfunction

    function automatic logic gray_ok(input logic [1:0] g);
        return g != 2'b10;
    endfunction

    // Slot one step behind the reader in the 0->1->2 ring
    function automatic logic [1:0] slot_behind(input logic [1:0] s);
        logic [1:0] r;
        case (s)
            2'd0:    r = 2'd2;
            2'd1:    r = 2'd0;
            default: r = 2'd1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pp_rx_fill.sv
module pp_rx_fill #(
    parameter int FRAME_BYTES = 64,
    parameter int FILL_W      = $clog2(FRAME_BYTES),
    parameter int LEN_W       = $clog2(FRAME_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_valid,
    input  logic [LEN_W-1:0]  pkt_len,
    output logic              act_sel,
    output logic [FILL_W-1:0] fill,
    output logic              done,
    output logic              done_buf
);
    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum      = SUM_W'(fill) + SUM_W'(pkt_len);
        done     = pkt_valid && (sum >= SUM_W'(FRAME_BYTES));
        done_buf = act_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_sel <= 1'b0;
            fill    <= '0;
        end else if (pkt_valid) begin
            if (done) begin
                act_sel <= ~act_sel;
                fill    <= FILL_W'(sum - SUM_W'(FRAME_BYTES));
            end else begin
                fill    <= FILL_W'(sum);
            end
        end
    end
endmodule

// File: rtl/pp_rx_ready.sv
module pp_rx_ready #(
    parameter int OVR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  logic             done_buf,
    input  logic             take,
    output logic             rdy,
    output logic             rdy_buf,
    output logic [OVR_W-1:0] overrun_cnt
);
    logic still_pending;

    assign still_pending = rdy && !take;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy         <= 1'b0;
            rdy_buf     <= 1'b0;
            overrun_cnt <= '0;
        end else begin
            if (done) begin
                rdy     <= 1'b1;
                rdy_buf <= done_buf;
                if (still_pending)
                    overrun_cnt <= overrun_cnt + 1'b1;
            end else if (take) begin
                rdy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pp_rx_cmd.sv
module pp_rx_cmd
    import pp_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] rd_gray,
    input  logic       rdy,
    input  logic       rdy_buf,
    output logic       take,
    output copy_cmd_t  cmd
);
    copy_cmd_t cmd_n;

    always_comb begin
        take        = tick && rdy && gray_ok(rd_gray);
        cmd_n.valid = take;
        cmd_n.src   = rdy_buf;
        cmd_n.dst   = slot_behind(gray_to_slot(rd_gray));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= '0;
        end else begin
            cmd <= cmd_n;
        end
    end
endmodule

// File: rtl/pp_rx_ctrl.sv
module pp_rx_ctrl
    import pp_rx_pkg::*;
#(
    parameter int          FRAME_BYTES = 1280 * 720 * 3,
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] NET_BASE    = 32'h1000_0000,
    parameter int          OVR_W       = 8,
    localparam int         LEN_W       = $clog2(FRAME_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_valid,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic              tick,
    input  logic [1:0]        rd_gray,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              copy_valid,
    output logic              copy_src_buf,
    output logic [ADDR_W-1:0] copy_src_base,
    output logic [1:0]        copy_dst_slot,
    output logic [OVR_W-1:0]  overrun_cnt
);
    localparam int FILL_W = $clog2(FRAME_BYTES);
    localparam logic [ADDR_W-1:0] BASE0 = ADDR_W'(NET_BASE);
    localparam logic [ADDR_W-1:0] BASE1 = ADDR_W'(NET_BASE) + ADDR_W'(FRAME_BYTES);

    logic              act_sel;
    logic [FILL_W-1:0] fill;
    logic              done;
    logic              done_buf;
    logic              rdy;
    logic              rdy_buf;
    logic              take;
    copy_cmd_t         cmd;

    pp_rx_fill #(
        .FRAME_BYTES (FRAME_BYTES),
        .FILL_W      (FILL_W),
        .LEN_W       (LEN_W)
    ) u_fill (
        .clk       (clk),
        .rst       (rst),
        .pkt_valid (pkt_valid),
        .pkt_len   (pkt_len),
        .act_sel   (act_sel),
        .fill      (fill),
        .done      (done),
        .done_buf  (done_buf)
    );

    pp_rx_ready #(
        .OVR_W (OVR_W)
    ) u_ready (
        .clk         (clk),
        .rst         (rst),
        .done        (done),
        .done_buf    (done_buf),
        .take        (take),
        .rdy         (rdy),
        .rdy_buf     (rdy_buf),
        .overrun_cnt (overrun_cnt)
    );

    pp_rx_cmd u_cmd (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .rd_gray (rd_gray),
        .rdy     (rdy),
        .rdy_buf (rdy_buf),
        .take    (take),
        .cmd     (cmd)
    );

    always_comb begin
        wr_addr       = (act_sel ? BASE1 : BASE0) + ADDR_W'(fill);
        copy_valid    = cmd.valid;
        copy_src_buf  = cmd.src;
        copy_src_base = cmd.src ? BASE1 : BASE0;
        copy_dst_slot = cmd.dst;
    end
endmodule

// File: rtl/pp_rx_ctrl_chk.sv
module pp_rx_ctrl_chk
    import pp_rx_pkg::*;
#(
    parameter int FRAME_BYTES = 64,
    parameter int FILL_W      = 6,
    parameter int OVR_W       = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [1:0]        rd_gray,
    input logic              act_sel,
    input logic [FILL_W-1:0] fill,
    input logic              rdy,
    input logic              copy_valid,
    input logic              copy_src_buf,
    input logic [1:0]        copy_dst_slot,
    input logic [OVR_W-1:0]  overrun_cnt
);
    // R1
    p_reset_idle_r1: assert property (@(posedge clk) $fell(rst) |-> !copy_valid && overrun_cnt == '0);

    // R3, R4
    p_fill_bound_r3: assert property (@(posedge clk) disable iff (rst) 32'(fill) < FRAME_BYTES);

    // R5
    p_cmd_after_tick_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && copy_valid |-> $past(tick));

    // R5
    p_src_not_active_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && copy_valid |-> copy_src_buf != $past(act_sel));

    // R6
    p_dst_behind_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && copy_valid |-> copy_dst_slot == slot_behind(gray_to_slot($past(rd_gray))));

    // R7
    p_no_cmd_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && copy_valid |-> $past(rdy));

    // R10
    p_bad_gray_r10: assert property (@(posedge clk) disable iff (rst)
        tick && rd_gray == 2'b10 |=> !copy_valid);

    // R9
    p_overrun_step_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> overrun_cnt == $past(overrun_cnt) || overrun_cnt == $past(overrun_cnt) + 1'b1);
endmodule

bind pp_rx_ctrl pp_rx_ctrl_chk #(
    .FRAME_BYTES (FRAME_BYTES),
    .FILL_W      (FILL_W),
    .OVR_W       (OVR_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .rd_gray       (rd_gray),
    .act_sel       (act_sel),
    .fill          (fill),
    .rdy           (rdy),
    .copy_valid    (copy_valid),
    .copy_src_buf  (copy_src_buf),
    .copy_dst_slot (copy_dst_slot),
    .overrun_cnt   (overrun_cnt)
);

// File: tb/pp_rx_ctrl_bench.sv
module pp_rx_ctrl_bench;
    localparam int          F      = 40;
    localparam int          AW     = 16;
    localparam logic [31:0] BASE   = 32'h0000_0100;
    localparam int          OW     = 8;
    localparam int          LW     = $clog2(F + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pkt_valid = 1'b0;
    logic [LW-1:0] pkt_len = '0;
    logic          tick = 1'b0;
    logic [1:0]    rd_gray = 2'b00;
    logic [AW-1:0] wr_addr;
    logic          copy_valid;
    logic          copy_src_buf;
    logic [AW-1:0] copy_src_base;
    logic [1:0]    copy_dst_slot;
    logic [OW-1:0] overrun_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    pp_rx_ctrl #(
        .FRAME_BYTES (F),
        .ADDR_W      (AW),
        .NET_BASE    (BASE),
        .OVR_W       (OW)
    ) u_pp_rx_ctrl (
        .clk           (clk),
        .rst           (rst),
        .pkt_valid     (pkt_valid),
        .pkt_len       (pkt_len),
        .tick          (tick),
        .rd_gray       (rd_gray),
        .wr_addr       (wr_addr),
        .copy_valid    (copy_valid),
        .copy_src_buf  (copy_src_buf),
        .copy_src_base (copy_src_base),
        .copy_dst_slot (copy_dst_slot),
        .overrun_cnt   (overrun_cnt)
    );

    // Behavioural reference model
    int m_sel, m_fill, m_rdy, m_rbuf, m_over, m_cv, m_src, m_dst;
    int q_slot[4] = '{0, 1, -1, 2};   // indexed by gray code

    always @(posedge clk) begin
        if (rst) begin
            m_sel = 0; m_fill = 0; m_rdy = 0; m_rbuf = 0; m_over = 0;
            m_cv = 0; m_src = 0; m_dst = 0;
        end else begin
            int rs;
            int tot;
            bit cmd;
            bit pending;
            rs  = q_slot[rd_gray];
            cmd = tick && (m_rdy != 0) && (rs >= 0);
            m_cv = cmd ? 1 : 0;
            if (cmd) begin
                m_src = m_rbuf;
                m_dst = (rs + 2) % 3;
            end
            pending = (m_rdy != 0) && !cmd;
            m_rdy   = pending ? 1 : 0;
            if (pkt_valid) begin
                tot = m_fill + int'(pkt_len);
                if (tot >= F) begin
                    if (pending) m_over = (m_over + 1) % 256;
                    m_rdy  = 1;
                    m_rbuf = m_sel;
                    m_sel  = 1 - m_sel;
                    m_fill = tot - F;
                end else begin
                    m_fill = tot;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            int ea;
            ea = int'(BASE) + m_sel * F + m_fill;
            chk(int'(wr_addr) == ea, "R2 wr_addr", int'(wr_addr), ea);
            chk(int'(copy_valid) == m_cv, "R5 copy_valid", int'(copy_valid), m_cv);
            if (m_cv != 0) begin
                chk(int'(copy_src_buf) == m_src, "R5 copy_src_buf", int'(copy_src_buf), m_src);
                chk(int'(copy_src_base) == int'(BASE) + m_src * F, "R5 copy_src_base",
                    int'(copy_src_base), int'(BASE) + m_src * F);
                chk(int'(copy_dst_slot) == m_dst, "R6 copy_dst_slot", int'(copy_dst_slot), m_dst);
            end
            chk(int'(overrun_cnt) == m_over, "R9 overrun_cnt", int'(overrun_cnt), m_over);
        end
    end

    // Drive one cycle starting at a negedge; returns at the next negedge
    task automatic step(input bit pv, input int len, input bit tk, input logic [1:0] g);
        pkt_valid = pv;
        pkt_len   = LW'(len);
        tick      = tk;
        rd_gray   = g;
        @(negedge clk);
        pkt_valid = 1'b0;
        pkt_len   = '0;
        tick      = 1'b0;
    endtask

    task automatic finish_run;
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(wr_addr == AW'(BASE), "R1 wr_addr", int'(wr_addr), int'(BASE));
        chk(copy_valid == 1'b0, "R1 copy_valid", int'(copy_valid), 0);
        chk(overrun_cnt == '0, "R1 overrun_cnt", int'(overrun_cnt), 0);

        // R7 tick with nothing ready
        step(0, 0, 1, 2'b00);
        chk(copy_valid == 1'b0, "R7 idle tick", int'(copy_valid), 0);

        // R2 partial fill, R12 zero length
        step(1, 10, 0, 2'b00);
        chk(int'(wr_addr) == 'h10A, "R2 fill", int'(wr_addr), 'h10A);
        step(1, 0, 0, 2'b00);
        chk(int'(wr_addr) == 'h10A, "R12 zero len", int'(wr_addr), 'h10A);

        // R3 exact fill switches buffers
        step(1, 30, 0, 2'b00);
        chk(int'(wr_addr) == 'h128, "R3 switch", int'(wr_addr), 'h128);

        // R5, R6 copy with reader in slot 1
        step(0, 0, 1, 2'b01);
        chk(copy_valid == 1'b1, "R5 cmd", int'(copy_valid), 1);
        chk(copy_src_buf == 1'b0, "R5 src", int'(copy_src_buf), 0);
        chk(copy_dst_slot == 2'd0, "R6 dst gray01", int'(copy_dst_slot), 0);

        // R8 flag cleared
        step(0, 0, 1, 2'b01);
        chk(copy_valid == 1'b0, "R8 no repeat", int'(copy_valid), 0);

        // R4 split packet: 35 + 10 in buffer 1 -> 5 in buffer 0
        step(1, 35, 0, 2'b00);
        step(1, 10, 0, 2'b00);
        chk(int'(wr_addr) == 'h105, "R4 split", int'(wr_addr), 'h105);

        // R10 bad gray code holds the request
        step(0, 0, 1, 2'b10);
        chk(copy_valid == 1'b0, "R10 bad gray", int'(copy_valid), 0);
        step(0, 0, 1, 2'b11);
        chk(copy_valid == 1'b1, "R10 retained", int'(copy_valid), 1);
        chk(copy_src_buf == 1'b1, "R5 src buf1", int'(copy_src_buf), 1);
        chk(copy_dst_slot == 2'd1, "R6 dst gray11", int'(copy_dst_slot), 1);

        // R9 overrun: two completions with no tick between
        step(1, 35, 0, 2'b00);
        step(1, 40, 0, 2'b00);
        chk(overrun_cnt == 8'd1, "R9 overrun", int'(overrun_cnt), 1);
        step(0, 0, 1, 2'b00);
        chk(copy_src_buf == 1'b1, "R9 newest", int'(copy_src_buf), 1);
        chk(copy_dst_slot == 2'd2, "R6 dst gray00", int'(copy_dst_slot), 2);

        // R11 tick and completion in the same cycle
        step(1, 40, 0, 2'b00);
        step(1, 40, 1, 2'b00);
        chk(copy_valid == 1'b1 && copy_src_buf == 1'b0, "R11 old buf", int'(copy_src_buf), 0);
        chk(overrun_cnt == 8'd1, "R11 no overrun", int'(overrun_cnt), 1);
        step(0, 0, 1, 2'b01);
        chk(copy_valid == 1'b1 && copy_src_buf == 1'b1, "R11 new kept", int'(copy_src_buf), 1);

        // Random mix, compared to the model every cycle
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] g;
            int k;
            k = int'($urandom % 4);
            g = (k == 0) ? 2'b00 : (k == 1) ? 2'b01 : (k == 2) ? 2'b11 : 2'b10;
            step(($urandom % 3) == 0, int'($urandom % (F + 1)), ($urandom % 9) == 0, g);
        end
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule